// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Access Controller

This block is the control path of a pipelined burst SRAM that stores 36-bit words as four 9-bit byte lanes. On every rising clock edge it samples three chip enables, two address strobes (one meant for a processor and one for a memory controller), a burst advance input, a global write, a byte-write enable and four per-lane byte-write selects. From these it decides whether the edge starts a read, performs a write, continues a burst or deselects the part. It then issues array read and write strobes with per-lane write enables, and it controls the enable of the data output drivers.

A read passes through a registered output stage, so its word appears one clock after the edge that started it. A write launched by the processor strobe takes two edges: the first loads the address and the second carries the write controls. A write launched by the controller strobe completes on its own edge. A small word array sits inside the block so that data can be observed at the ports. The array keeps its contents while the block is asleep. Sleep can be entered only when no access is in progress, and for a fixed number of cycles after sleep ends every strobe is refused and flagged.

Top module: `sram_pipe_ctl`

## Requirements
- R1: The part is selected only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. A recognised strobe that is not selected deselects the part and does not access the array.
- R2: A recognised strobe on a selected part with no write lane active starts a read. The addressed word is on `rdata` after the rising edge that follows the start edge.
- R3: On a processor-strobe edge, `gw_n`, `bwe_n`, `bw_n` and `adv_n` have no effect and the edge starts a read. On the next edge, if no strobe is present and `adv_n`=1, an active write control writes to the loaded address.
- R4: The processor strobe is recognised only when `ce_a_n`=0. When both strobes are low and it is recognised, the controller strobe is ignored.
- R5: A controller strobe (`strb_ctrl_n`=0, processor strobe not recognised) on a selected part with a write lane active writes `wdata` at `addr` on that same edge.
- R6: `gw_n`=0 writes all four lanes, whatever the values of `bwe_n` and `bw_n`.
- R7: With `gw_n`=1 and `bwe_n`=0, each lane i whose `bw_n[i]`=0 is written, where lane i is bits [9i+8:9i]. With `gw_n`=1 and `bwe_n`=1, no lane is written and the access is a read.
- R8: While a burst is active and no strobe is present, `adv_n`=0 moves the burst address to its next value and reads or writes there. The two low bits count up linearly and wrap from 3 to 0. The upper bits are held.
- R9: `dq_oe` = NOT `oe_n` AND output-on, and it follows `oe_n` without waiting for a clock. Output-on clears on the edge that deselects the part. After a start from the deselected state it stays clear for one cycle, then sets on the edge where the read data is captured.
- R10: A sleep request takes effect only while no burst is active. While asleep, and for `REC_CYC` edges after the edge that ends sleep, strobes are suppressed and `proto_err` is high whenever a strobe input is low. Stored words are kept.
- R11: When a write and the capture of a pending read fall on the same edge at the same address, the captured word carries the newly written lanes.
- R12: After reset, `dq_oe`, `rdata` and `proto_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_a_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| strb_proc_n | input | 1 | Processor address strobe, active low |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane byte-write selects, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Sleep request, active high |
| addr | input | ADDR_W | Word address |
| wdata | input | 36 | Write data |
| rdata | output | 36 | Output register contents |
| dq_oe | output | 1 | Data output driver enable |
| arr_rd | output | 1 | Array read strobe for this edge |
| arr_wr | output | 1 | Array write strobe for this edge |
| arr_we | output | 4 | Per-lane array write enables |
| proto_err | output | 1 | A strobe arrived while strobes are suppressed |

## Verification
Two functions share an edge in the processor-strobe write. The edge that captures the read started by the strobe is the same edge that writes the word at that address. The bench provokes this with a processor strobe followed by a global write on the next edge. It expects the output register to hold the new word, not the old one. The second overlap is a strobe arriving during sleep or its recovery window. There the strobe and the suppression meet in one cycle. The bench judges this by `proto_err` and by reading the address back after recovery, which must return its value from before sleep.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;

  typedef logic [LANES-1:0]  lane_t;
  typedef logic [DATA_W-1:0] word_t;

  // which command path claimed the edge
  typedef enum logic [1:0] {SRC_NONE, SRC_PROC, SRC_CTRL, SRC_BURST} src_e;

  // lanes written for a given combination of write controls
  function automatic lane_t lanes_of(logic gw_n, logic bwe_n, lane_t bw_n);
    if (!gw_n)  return '1;
    if (!bwe_n) return ~bw_n;
    return '0;
  endfunction

  // overlay the enabled lanes of new_w onto old_w
  function automatic word_t merge_lanes(word_t old_w, word_t new_w, lane_t we);
    word_t r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (we[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  // linear two-bit burst step
  function automatic logic [1:0] burst_next(logic [1:0] cur);
    return cur + 2'd1;
  endfunction
endpackage

// File: rtl/sram_pipe_decode.sv
module sram_pipe_decode
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              strb_proc_n,
  input  logic              strb_ctrl_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  lane_t             bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              active,
  input  logic [ADDR_W-1:0] baddr,
  input  logic              blocked,
  output logic              op_rd,
  output logic              op_wr,
  output lane_t             op_lanes,
  output logic [ADDR_W-1:0] op_addr,
  output logic              op_start,
  output logic              op_desel,
  output logic              op_err,
  output src_e              op_src
);
  logic  sel, p_hit, c_hit;
  lane_t wl;

  assign sel   = !ce_a_n && ce_b && !ce_c_n;
  assign p_hit = !strb_proc_n && !ce_a_n;
  assign c_hit = !strb_ctrl_n && !p_hit;
  assign wl    = lanes_of(gw_n, bwe_n, bw_n);
  assign op_err = blocked && (!strb_proc_n || !strb_ctrl_n);

  always_comb begin
    op_rd    = 1'b0;
    op_wr    = 1'b0;
    op_lanes = '0;
    op_addr  = addr;
    op_start = 1'b0;
    op_desel = 1'b0;
    op_src   = SRC_NONE;
    if (!blocked) begin
      if (p_hit) begin
        op_src = SRC_PROC;
        if (sel) begin
          op_rd    = 1'b1;
          op_start = 1'b1;
        end else begin
          op_desel = 1'b1;
        end
      end else if (c_hit) begin
        op_src = SRC_CTRL;
        if (sel) begin
          op_start = 1'b1;
          if (wl != '0) begin
            op_wr    = 1'b1;
            op_lanes = wl;
          end else begin
            op_rd = 1'b1;
          end
        end else begin
          op_desel = 1'b1;
        end
      end else if (active) begin
        op_src  = SRC_BURST;
        op_addr = adv_n ? baddr : {baddr[ADDR_W-1:2], burst_next(baddr[1:0])};
        if (wl != '0) begin
          op_wr    = 1'b1;
          op_lanes = wl;
        end else if (!adv_n) begin
          op_rd = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sram_pipe_sleep.sv
module sram_pipe_sleep #(
  parameter int REC_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic busy,
  output logic asleep,
  output logic blocked
);
  localparam int RW = $clog2(REC_CYC + 1);

  logic          asleep_q;
  logic [RW-1:0] rec_q;
  logic          wake;

  assign wake    = asleep_q && !sleep_req;
  assign asleep  = asleep_q;
  assign blocked = asleep_q || (rec_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
      rec_q    <= '0;
    end else begin
      asleep_q <= sleep_req && (asleep_q || !busy);
      if (wake)             rec_q <= RW'(REC_CYC);
      else if (rec_q != '0) rec_q <= rec_q - 1'b1;
    end
  end

  AST_SLEEP_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(asleep_q) |-> !$past(busy)) else $error("sleep entered while busy"); // R10
  AST_RECOVERY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) wake |=> blocked) else $error("recovery window missing"); // R10
endmodule

// File: rtl/sram_pipe_store.sv
module sram_pipe_store
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  lane_t             wr_lanes,
  input  word_t             wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output word_t             rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  word_t mem [DEPTH];
  word_t dout_q;
  logic  wr_hits_rd;

  assign wr_hits_rd = wr_en && (wr_addr == rd_addr);
  assign rdata      = dout_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= merge_lanes(mem[wr_addr], wr_data, wr_lanes);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dout_q <= '0;
    else if (rd_en)
      dout_q <= wr_hits_rd ? merge_lanes(mem[rd_addr], wr_data, wr_lanes) : mem[rd_addr];
  end

  AST_BYPASS_NEW: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && wr_en && wr_lanes == '1 && wr_addr == rd_addr) |=> rdata == $past(wr_data)) else $error("collision returned stale word"); // R11
  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> $stable(rdata)) else $error("output register moved without a read"); // R2
endmodule

// File: rtl/sram_pipe_ctl.sv
module sram_pipe_ctl
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int REC_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              strb_proc_n,
  input  logic              strb_ctrl_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [3:0]        bw_n,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic [35:0]       wdata,
  output logic [35:0]       rdata,
  output logic              dq_oe,
  output logic              arr_rd,
  output logic              arr_wr,
  output logic [3:0]        arr_we,
  output logic              proto_err
);
  logic              active_q, rd_v_q, out_on_q;
  logic [ADDR_W-1:0] baddr_q, rd_a_q;
  logic              op_rd, op_wr, op_start, op_desel, op_err;
  lane_t             op_lanes;
  logic [ADDR_W-1:0] op_addr;
  src_e              op_src;
  logic              asleep, blocked;

  sram_pipe_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .addr(addr),
    .active(active_q), .baddr(baddr_q), .blocked(blocked),
    .op_rd(op_rd), .op_wr(op_wr), .op_lanes(op_lanes), .op_addr(op_addr),
    .op_start(op_start), .op_desel(op_desel), .op_err(op_err), .op_src(op_src)
  );

  sram_pipe_sleep #(.REC_CYC(REC_CYC)) u_slp (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep), .busy(active_q),
    .asleep(asleep), .blocked(blocked)
  );

  sram_pipe_store #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(op_wr), .wr_addr(op_addr),
    .wr_lanes(op_lanes), .wr_data(wdata), .rd_en(rd_v_q), .rd_addr(rd_a_q),
    .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      baddr_q  <= '0;
      rd_v_q   <= 1'b0;
      rd_a_q   <= '0;
      out_on_q <= 1'b0;
    end else begin
      if (op_desel)      active_q <= 1'b0;
      else if (op_start) active_q <= 1'b1;
      if (op_rd || op_wr) baddr_q <= op_addr;
      rd_v_q <= op_rd;
      if (op_rd) rd_a_q <= op_addr;
      if (op_desel || asleep) out_on_q <= 1'b0;
      else if (rd_v_q)        out_on_q <= 1'b1;
    end
  end

  assign dq_oe     = out_on_q & ~oe_n;
  assign arr_rd    = op_rd;
  assign arr_wr    = op_wr;
  assign arr_we    = op_lanes;
  assign proto_err = op_err;

  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n) op_desel |=> !dq_oe) else $error("driver on after deselect"); // R9
  AST_FIRST_CYCLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n) (op_start && !active_q) |=> !dq_oe) else $error("driver on in first selected cycle"); // R9
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) op_err |-> !(arr_rd || arr_wr)) else $error("suppressed strobe reached the array"); // R10
  AST_PROC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (op_src == SRC_PROC) |-> !arr_wr) else $error("write on processor strobe edge"); // R3
endmodule

// File: tb/test_sram_pipe_ctl.sv
module test_sram_pipe_ctl;
  localparam int CLK_PER = 10;
  localparam int AW = 8;
  localparam int REC = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ce_a_n, ce_b, ce_c_n, proc_n, ctrl_n, adv_n, gw_n, bwe_n, oe_n, sleep;
  logic [3:0] bw_n;
  logic [AW-1:0] addr;
  logic [35:0] wdata, rdata;
  logic dq_oe, arr_rd, arr_wr, proto_err;
  logic [3:0] arr_we;

  always #(CLK_PER/2) clk = ~clk;

  sram_pipe_ctl #(.ADDR_W(AW), .REC_CYC(REC)) i_sram_pipe_ctl (
    .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .strb_proc_n(proc_n), .strb_ctrl_n(ctrl_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dq_oe(dq_oe), .arr_rd(arr_rd), .arr_wr(arr_wr),
    .arr_we(arr_we), .proto_err(proto_err)
  );

  typedef struct {int due; logic [35:0] exp; string tag;} exp_t;
  exp_t sb[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [35:0] mdl [256];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare queued read results when they fall due
  always @(posedge clk) begin
    #(CLK_PER/4);
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(rdata === e.exp, e.tag, rdata, e.exp);
    end
  end

  function automatic logic [35:0] pat(int a, int s);
    return 36'((a * 36'h2_5A5A5) ^ (s * 36'h7_13579) ^ 36'h8_0F0F0);
  endfunction

  // bench-side lane overlay, done bit by bit
  function automatic logic [35:0] overlay(logic [35:0] o, logic [35:0] n, logic [3:0] ln);
    logic [35:0] r;
    for (int b = 0; b < 36; b++) r[b] = ln[b/9] ? n[b] : o[b];
    return r;
  endfunction

  function automatic logic [3:0] lanes_exp(logic g, logic be, logic [3:0] bw);
    if (g == 1'b0) return 4'hF;
    return (be == 1'b0) ? ~bw : 4'h0;
  endfunction

  task automatic idle_in();
    ce_a_n = 0; ce_b = 1; ce_c_n = 0; proc_n = 1; ctrl_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // controller-strobe access: write when a lane is enabled, otherwise read
  task automatic ctrl_acc(int a, logic [35:0] d, logic g, logic be, logic [3:0] bw, string tag);
    logic [3:0] ln;
    idle_in(); ctrl_n = 0; addr = AW'(a); wdata = d; gw_n = g; bwe_n = be; bw_n = bw;
    ln = lanes_exp(g, be, bw);
    if (ln != 0) mdl[a] = overlay(mdl[a], d, ln);
    else sb.push_back('{cyc + 2, mdl[a], tag});
    step();
  endtask

  task automatic ctrl_read(int a, string tag);
    ctrl_acc(a, 36'h0, 1'b1, 1'b1, 4'hF, tag);
  endtask

  task automatic adv_read(int a, string tag);
    idle_in(); adv_n = 0;
    sb.push_back('{cyc + 2, mdl[a], tag});
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PER * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 36'h0, 36'h1);
    finish_run();
  end

  initial begin
    rst_n = 0; idle_in(); oe_n = 0; sleep = 0; addr = '0; wdata = '0;
    repeat (3) step();
    check(dq_oe === 1'b0, "R12 dq_oe", 36'(dq_oe), 36'h0);
    check(rdata === 36'h0, "R12 rdata", rdata, 36'h0);
    check(proto_err === 1'b0, "R12 proto_err", 36'(proto_err), 36'h0);
    rst_n = 1; step();

    for (int a = 0; a < 16; a++) ctrl_acc(a, pat(a, 1), 1'b0, 1'b1, 4'hF, "R5 fill");
    for (int a = 64; a < 68; a++) ctrl_acc(a, pat(a, 1), 1'b0, 1'b1, 4'hF, "R5 fill");

    ctrl_read(3, "R2 R5 read after single-edge write");
    ctrl_acc(5, pat(5, 2), 1'b0, 1'b1, 4'hF, "R6");
    ctrl_read(5, "R6 global write all lanes");
    ctrl_acc(6, pat(6, 3), 1'b1, 1'b0, 4'b1010, "R7");
    ctrl_read(6, "R7 byte lanes 0 and 2");
    ctrl_acc(7, pat(7, 4), 1'b1, 1'b1, 4'b0000, "R7 bwe high is a read");
    ctrl_read(7, "R7 no lane written");

    // processor write: read launched, then written on the second edge
    idle_in(); proc_n = 0; addr = 8'd10; gw_n = 1;
    sb.push_back('{cyc + 2, pat(10, 5), "R11 collision returns new word"});
    mdl[10] = pat(10, 5);
    step();
    idle_in(); gw_n = 0; wdata = pat(10, 5); addr = 8'd200; step();
    ctrl_read(10, "R3 second-edge write");

    // processor strobe edge ignores write controls
    idle_in(); proc_n = 0; addr = 8'd11; gw_n = 0; wdata = pat(11, 9);
    sb.push_back('{cyc + 2, mdl[11], "R3 first edge is a read"});
    step();
    idle_in(); step();
    ctrl_read(11, "R3 write controls ignored");

    // both strobes: processor wins, controller write dropped
    idle_in(); proc_n = 0; ctrl_n = 0; addr = 8'd12; gw_n = 0; wdata = pat(12, 9);
    sb.push_back('{cyc + 2, mdl[12], "R4 processor strobe wins"});
    step();
    idle_in(); step();
    ctrl_read(12, "R4 controller write dropped");

    // processor strobe ignored with ce_a_n high: burst continues instead
    ctrl_read(8, "R2");
    idle_in(); ce_a_n = 1; proc_n = 0; adv_n = 0;
    sb.push_back('{cyc + 2, mdl[9], "R4 R8 ignored strobe, advance"});
    step();

    // burst wrap on the low two bits
    ctrl_read(14, "R8 start");
    adv_read(15, "R8 step 15");
    adv_read(12, "R8 wrap to 12");
    adv_read(13, "R8 step 13");
    idle_in(); step();

    // burst write
    ctrl_acc(64, pat(64, 7), 1'b0, 1'b1, 4'hF, "R8");
    idle_in(); adv_n = 0; gw_n = 0; wdata = pat(65, 7); mdl[65] = pat(65, 7); step();
    ctrl_read(65, "R8 burst write");

    // output driver timing and deselect
    ctrl_read(2, "R2");
    idle_in(); step();
    check(dq_oe === 1'b1, "R9 driver on", 36'(dq_oe), 36'h1);
    idle_in(); ce_c_n = 1; ctrl_n = 0; gw_n = 0; addr = 8'd2; wdata = pat(2, 9); step();
    check(dq_oe === 1'b0, "R9 off after deselect", 36'(dq_oe), 36'h0);
    ctrl_read(2, "R1 deselected write ignored");
    check(dq_oe === 1'b0, "R9 first selected cycle", 36'(dq_oe), 36'h0);
    idle_in(); step();
    check(dq_oe === 1'b1, "R9 on after capture", 36'(dq_oe), 36'h1);
    oe_n = 1; #1;
    check(dq_oe === 1'b0, "R9 oe_n asynchronous", 36'(dq_oe), 36'h0);
    oe_n = 0;

    // sleep request while a burst is active has no effect
    sleep = 1;
    idle_in(); ctrl_n = 0; addr = 8'd3; #1;
    check(proto_err === 1'b0, "R10 no sleep while busy", 36'(proto_err), 36'h0);
    sb.push_back('{cyc + 2, mdl[3], "R10 read while sleep pending"});
    step();
    idle_in(); ce_b = 0; ctrl_n = 0; step();
    idle_in(); ce_b = 0; step();
    step();
    idle_in(); ctrl_n = 0; addr = 8'd3; gw_n = 0; wdata = pat(3, 9); #1;
    check(proto_err === 1'b1, "R10 strobe while asleep", 36'(proto_err), 36'h1);
    step();
    sleep = 0; idle_in(); ce_b = 0; step();
    for (int k = 0; k < REC; k++) begin
      idle_in(); ctrl_n = 0; addr = 8'd3; gw_n = 0; wdata = pat(3, 9); #1;
      check(proto_err === 1'b1, "R10 strobe in recovery", 36'(proto_err), 36'h1);
      step();
    end
    idle_in(); ctrl_n = 0; addr = 8'd3; #1;
    check(proto_err === 1'b0, "R10 recovery over", 36'(proto_err), 36'h0);
    sb.push_back('{cyc + 2, mdl[3], "R10 data preserved"});
    step();
    idle_in();
    repeat (4) step();
    check(sb.size() == 0, "R2 all reads seen", 36'(sb.size()), 36'h0);
    finish_run();
  end
endmodule